// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block models a 256-word by 8-bit serial EEPROM that answers as a slave on a two-wire bus. A fast system clock samples SCL and SDA, and the block finds START and STOP conditions from edges of SDA while SCL is high. After a START, the first byte names the device and the operation. In a write, the next byte sets the internal address pointer, and every byte after that lands in an eight-entry page buffer.

The buffered bytes move into the memory array only after STOP. This happens in a timed internal write cycle, and while it runs the block refuses every control byte. A read returns bytes from the current address pointer, which advances over the full eight bits after each byte. The block drives SDA open-drain: the output `sda_oe` high means the line is pulled low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged (`sda_oe` high during the ninth SCL pulse) only when its upper nibble is 1010 and no write cycle is running. Bits 3..1 are ignored and bit 0 selects read (1) or write (0). A byte with any other upper nibble gets no acknowledge, and the rest of that transaction is ignored.
- R2: In a write, the byte after the control byte is loaded into the address pointer and acknowledged. Each later byte is acknowledged as data.
- R3: A STOP after at least one complete data byte starts the internal write cycle, which stores the buffered bytes in the memory array.
- R4: Up to eight data bytes of one transaction are held in the page buffer and committed together after STOP.
- R5: Each data byte increments only the low three bits of the address pointer, so bits 7..3 stay fixed. A ninth or later byte wraps and overwrites the earlier byte at the same position.
- R6: `busy` goes high on the clock after STOP is detected and stays high for exactly WRITE_CLKS clocks. While it is high, no control byte is acknowledged.
- R7: A STOP before any complete data byte starts no write cycle, but the address pointer keeps the loaded address.
- R8: A read returns the byte at the address pointer, MSB first, and then increments the pointer over all eight bits, so 0xFF wraps to 0x00. A master NACK followed by STOP ends the read. A later read continues from where the pointer stands.
- R9: A START in the middle of a byte restarts bit counting, and the next byte is taken as a control byte.
- R10: After reset, `sda_oe` and `busy` are low, the pointer is 0x00, and every memory word reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Resolved level of the bus data line |
| sda_oe | output | 1 | High pulls the data line low |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two activities can fall in the same cycle: the commit sequencer writing page bytes into the array, and the bus front end decoding a new control byte. The bench provokes this by sending a read control byte right after each STOP that starts a write, while `busy` is still high. It expects a NACK on that byte, an unchanged `busy` length, and, in a final read of all 256 words, memory contents that match a model built only from the accepted writes.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int WORDS      = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WRITE_CLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  output logic sda_oe,
  output logic busy
);
  localparam int AW = $clog2(WORDS);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(WRITE_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_READ} st_t;

  logic [2:0] scl_r, sda_r;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t                state;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg, txbyte;
  logic [AW-1:0]      ptr;
  logic [7:0]         mem  [WORDS];
  logic [7:0]         page [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [AW-PW-1:0]   base;
  logic [TW-1:0]      tmr;

  assign scl_s = scl_r[1];
  assign scl_p = scl_r[2];
  assign sda_s = sda_r[1];
  assign sda_p = sda_r[2];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_r <= '1;
      sda_r <= '1;
    end else begin
      scl_r <= {scl_r[1:0], scl};
      sda_r <= {sda_r[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txbyte <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      valid  <= '0;
      base   <= '0;
      tmr    <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) page[i] <= '0;
    end else begin
      if (busy) begin
        if (tmr < TW'(PAGE_BYTES) && valid[tmr[PW-1:0]])
          mem[{base, tmr[PW-1:0]}] <= page[tmr[PW-1:0]];
        if (tmr == TW'(WRITE_CLKS - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end

      if (start_det) begin
        state  <= S_CTRL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (!busy) valid <= '0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
        if (state == S_WDATA && |valid && !busy) begin
          busy <= 1'b1;
          tmr  <= '0;
          base <= ptr[AW-1:PW];
        end
      end else if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (state == S_READ && sda_s) state <= S_IDLE;
        end else begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (state)
            S_CTRL: begin
              if (shreg[7:4] == 4'b1010 && !busy) begin
                sda_oe <= 1'b1;
                state  <= shreg[0] ? S_READ : S_ADDR;
              end else begin
                state <= S_IDLE;
              end
            end
            S_ADDR: begin
              ptr    <= shreg[AW-1:0];
              sda_oe <= 1'b1;
              state  <= S_WDATA;
            end
            S_WDATA: begin
              page[ptr[PW-1:0]]  <= shreg;
              valid[ptr[PW-1:0]] <= 1'b1;
              ptr[PW-1:0]        <= ptr[PW-1:0] + PW'(1);
              sda_oe             <= 1'b1;
            end
            S_READ:  sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt == 4'd0) begin
          if (state == S_READ) begin
            txbyte <= mem[ptr];
            sda_oe <= ~mem[ptr][7];
            ptr    <= ptr + AW'(1);
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (state == S_READ) begin
          txbyte <= txbyte << 1;
          sda_oe <= ~txbyte[6];
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_chk.sv
module eeprom_chk #(
  parameter int AW = 8,
  parameter int PW = 3,
  parameter int TW = 7,
  parameter int WRITE_CLKS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sda_oe,
  input logic          stop_det,
  input logic [2:0]    state,
  input logic [AW-1:0] ptr,
  input logic [TW-1:0] tmr
);
  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R3
  commit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R5
  page_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && $past(state) == 3'd3) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && $past(state) == 3'd0) |-> !sda_oe);

  // R6
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr < TW'(WRITE_CLKS));
endmodule

bind i2c_eeprom_slave eeprom_chk #(
  .AW(AW), .PW(PW), .TW(TW), .WRITE_CLKS(WRITE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe),
  .stop_det(stop_det), .state(state), .ptr(ptr), .tmr(tmr)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  localparam int CLK_P = 10;
  localparam int WC    = 400;
  localparam int Q     = 5;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_eeprom_slave #(.WRITE_CLKS(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  int checks = 0, fails = 0, busy_total = 0, cyc = 0;
  logic [7:0] mdl [256];
  logic [7:0] ptr_m = 8'h00;

  always @(negedge clk) if (busy) busy_total++;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic i_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    send_bit(nack);
  endtask

  // Write n bytes at addr; data computed from seed. Probes busy NACK after STOP.
  task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] seed);
    logic ack;
    int bt;
    logic [7:0] d;
    i_start();
    send_byte(8'hA0 | {4'h0, seed[2:0], 1'b0}, ack);
    chk("R1 ctrl ack (dont-care bits varied)", ack, 1);
    send_byte(addr, ack);
    chk("R2 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 29);
      send_byte(d, ack);
      chk("R2 data ack", ack, 1);
      mdl[{addr[7:3], 3'(addr[2:0] + 3'(i))}] = d;
    end
    ptr_m = {addr[7:3], 3'(addr[2:0] + 3'(n))};
    bt = busy_total;
    i_stop();
    if (n > 0) begin
      chk("R3 busy after stop", busy, 1);
      i_start();
      send_byte(8'hA1, ack);
      chk("R6 ctrl nack while busy", ack, 0);
      i_stop();
      while (busy) wt(1);
      chk("R6 busy length", busy_total - bt, WC);
    end else begin
      wt(WC);
      chk("R7 no write cycle without data", busy_total - bt, 0);
    end
  endtask

  task automatic do_read(input int n, input string req);
    logic ack;
    logic [7:0] b;
    i_start();
    send_byte(8'hA1 | {4'h0, ptr_m[2:0], 1'b0}, ack);
    chk("R8 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i == n - 1));
      chk(req, b, mdl[ptr_m]);
      ptr_m = ptr_m + 8'd1;
    end
    i_stop();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    wt(5);
    chk("R10 sda_oe in reset", sda_oe, 0);
    chk("R10 busy in reset", busy, 0);
    rst_n = 1'b1;
    wt(5);
    chk("R10 sda_oe after reset", sda_oe, 0);
    do_read(3, "R10 erased read from pointer 0");

    for (int k = 0; k < 6; k++) begin
      do_write(8'(k * 47 + 3), 1, 8'(k * 13 + 5));
      do_write(8'(k * 47 + 3), 0, 8'(k));
      do_read(1, "R3 byte write readback");
    end

    do_write(8'h40, 8, 8'h11);
    do_read(2, "R4 read after full page");
    do_write(8'h2E, 5, 8'h72);
    do_read(2, "R5 current address after wrapped page");
    do_write(8'h53, 11, 8'hC4);
    do_write(8'h50, 0, 8'h00);
    do_read(8, "R5 overwrite on wrap");

    i_start();
    send_byte(8'h20, ack);
    chk("R1 wrong code nack", ack, 0);
    send_byte(8'h10, ack);
    chk("R1 later byte ignored", ack, 0);
    send_byte(8'h99, ack);
    chk("R1 data ignored", ack, 0);
    i_stop();
    wt(20);
    chk("R1 no write cycle", busy, 0);

    i_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_write(8'h77, 1, 8'h5A);
    do_read(1, "R9 read after mid-byte restart");

    do_write(8'hFE, 0, 8'h00);
    do_read(4, "R8 pointer wraps 0xFF to 0x00");
    do_read(1, "R8 read continues");

    do_write(8'h00, 0, 8'h00);
    do_read(256, "R4 full array sweep");

    summary();
    $finish;
  end
endmodule